// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block takes a serial audio stream made of a bit clock, a frame-sync (left/right) line and a data line, and turns it into parallel words. The three serial inputs are asynchronous to the system clock. They are resynchronised, and every rising edge of the bit clock becomes a one-cycle sampling tick. A start event on the frame-sync line opens a frame. After a programmable number of bit periods the block samples a programmable number of words, each of a programmable length, into an assembly register.

The start event can be a falling edge, a rising edge or any edge of frame sync. This covers I2S-style framing (falling edge, delay 1), DSP-A-style framing (rising edge, delay 1) and an externally clocked stereo stream (either edge, one word per event). Each finished word is placed in a holding register and flagged valid until the consumer acknowledges it. If a word finishes while the previous one is still unread, the older word is kept and a sticky overrun flag is raised.

Top module: `audio_frame_rx`

## Requirements
- R1: With `cfgStartMode` = 0, a frame begins only on a falling edge of frame sync, as seen at consecutive bit-clock rising edges.
- R2: With `cfgStartMode` = 1, a frame begins only on a rising edge of frame sync.
- R3: With `cfgStartMode` = 2 or 3, a frame begins on either edge of frame sync.
- R4: The first data bit of a frame is the one sampled `cfgDelay` bit-clock rising edges after the edge at which the start event is seen. A value of 0 takes the first bit at the start edge itself.
- R5: Serial data is sampled at bit-clock rising edges. A data change while the bit clock is high has no effect.
- R6: Each word holds `cfgLenM1`+1 bits, right-justified in `wordData`, with all higher bits zero. Lengths of 8, 16, 24 and 32 bits are supported.
- R7: With `cfgMsbFirst` = 1, the first received bit of a word is its most significant bit. With 0, the first received bit lands at bit 0 and later bits at increasing positions.
- R8: Each start event yields exactly `cfgWordsM1`+1 words (1 or 2), received back to back with no gap between them.
- R9: A start event seen while a frame is in its delay or data phase is ignored. The exception is an event at the tick carrying the frame's final bit with `cfgDelay` ≥ 1, which opens the next frame back to back.
- R10: `wordValid` rises only when a word completes. While it is high, `wordValid` and `wordData` hold until `wordRead` is pulsed.
- R11: A word that completes while `wordValid` is high and `wordRead` is low is dropped, the held word is kept, and `overrun` is set. `overrun` stays set until `overrunClr` is pulsed.
- R12: After reset, `wordValid` and `overrun` are 0 and `wordData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitClk | input | 1 | Serial bit clock, asynchronous |
| frameSync | input | 1 | Frame-sync / left-right clock, asynchronous |
| serData | input | 1 | Serial data, asynchronous |
| cfgStartMode | input | 2 | 0 falling, 1 rising, 2 or 3 either edge |
| cfgDelay | input | 4 | Bit periods from start event to first bit |
| cfgLenM1 | input | 5 | Word length minus one |
| cfgWordsM1 | input | 1 | Words per frame minus one |
| cfgMsbFirst | input | 1 | 1: MSB first, 0: LSB first |
| wordRead | input | 1 | Consumer acknowledges the held word |
| overrunClr | input | 1 | Write-one-to-clear strobe for `overrun` |
| wordData | output | 32 | Last accepted word, right-justified |
| wordValid | output | 1 | Held word is unread |
| overrun | output | 1 | Sticky lost-word flag |

## Verification
The hardest case to reach from the ports is a start event on exactly the tick that carries a frame's last bit. That is the back-to-back stereo case, and it must be told apart from an ignored mid-frame edge. The bench builds its serial stream one bit tick at a time. It toggles frame sync on chosen tick indices, so both situations are produced deliberately. A mid-frame double toggle must leave the word count unchanged. A toggle on the final bit must produce a second, correctly aligned word. A sweep over length, word count, bit order, start mode and delay covers the rest. The bench also changes data in the middle of the high phase of every bit clock, so a design that samples on the wrong edge reads corrupted bits.

// File: rtl/afrx_pkg.sv
package afrx_pkg;
  localparam int MAX_BITS  = 32;
  localparam int LEN_W     = $clog2(MAX_BITS);
  localparam int MAX_WORDS = 2;
  localparam int WCNT_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int DLY_W     = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2
  } rxState_t;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic             takeBit;
    logic             firstBit;
    logic             wordDone;
    logic             frameDone;
    logic [LEN_W-1:0] bitPos;
  } rxStb_t;
endpackage

// File: rtl/afrx_front.sv
module afrx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       frameSync,
  input  logic       serData,
  input  logic [1:0] startMode,
  output logic       tick,
  output logic       bitVal,
  output logic       startEvt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][2:0] syncQ;
  logic bclkLast;
  logic fsLast;
  logic fsKnown;
  logic fsRise;
  logic fsFall;
  logic bclkNow;
  logic fsNow;

  // all three lines share one chain so they keep their relative timing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      for (int s = LAST; s > 0; s--) syncQ[s] <= syncQ[s-1];
      syncQ[0] <= {bitClk, frameSync, serData};
    end
  end

  assign bclkNow = syncQ[LAST][2];
  assign fsNow   = syncQ[LAST][1];
  assign bitVal  = syncQ[LAST][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bclkLast <= 1'b0;
    else       bclkLast <= bclkNow;
  end

  assign tick = bclkNow & ~bclkLast;

  // frame sync is compared between consecutive bit ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsLast  <= 1'b0;
      fsKnown <= 1'b0;
    end else if (tick) begin
      fsLast  <= fsNow;
      fsKnown <= 1'b1;
    end
  end

  assign fsRise = fsKnown & fsNow & ~fsLast;
  assign fsFall = fsKnown & ~fsNow & fsLast;

  always_comb begin
    unique case (startMode)
      2'd0:    startEvt = tick & fsFall;
      2'd1:    startEvt = tick & fsRise;
      default: startEvt = tick & (fsRise | fsFall);
    endcase
  end
endmodule

// File: rtl/afrx_ctrl.sv
module afrx_ctrl
  import afrx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              startEvt,
  input  logic [DLY_W-1:0]  cfgDelay,
  input  logic [LEN_W-1:0]  cfgLenM1,
  input  logic [WCNT_W-1:0] cfgWordsM1,
  input  logic              cfgMsbFirst,
  output rxStb_t            stb
);
  rxState_t          state;
  logic [LEN_W-1:0]  bitCnt;
  logic [WCNT_W-1:0] wordCnt;
  logic [DLY_W-1:0]  waitLeft;

  logic inFrameBit;
  logic idleStart0;
  logic takeBit;
  logic lastInWord;
  logic lastWord;
  logic frameDone;
  logic acceptWait;

  always_comb begin
    inFrameBit = tick & ((state == ST_RECV) | ((state == ST_WAIT) & (waitLeft == '0)));
    idleStart0 = startEvt & (state == ST_IDLE) & (cfgDelay == '0);
    takeBit    = inFrameBit | idleStart0;
    lastInWord = (bitCnt >= cfgLenM1);
    lastWord   = (wordCnt >= cfgWordsM1);
    frameDone  = takeBit & lastInWord & lastWord;
    // a new frame with a delay may open on the old frame's final bit
    acceptWait = startEvt & (cfgDelay != '0) & ((state == ST_IDLE) | frameDone);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitLeft <= '0;
    end else if (acceptWait) begin
      state    <= ST_WAIT;
      waitLeft <= cfgDelay - 1'b1;
    end else if (takeBit) begin
      state    <= frameDone ? ST_IDLE : ST_RECV;
    end else if (tick && state == ST_WAIT) begin
      waitLeft <= waitLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      wordCnt <= '0;
    end else if (takeBit) begin
      if (lastInWord) begin
        bitCnt  <= '0;
        wordCnt <= lastWord ? '0 : wordCnt + 1'b1;
      end else begin
        bitCnt  <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.takeBit   = takeBit;
    stb.firstBit  = takeBit & (bitCnt == '0);
    stb.wordDone  = takeBit & lastInWord;
    stb.frameDone = frameDone;
    stb.bitPos    = cfgMsbFirst ? (cfgLenM1 - bitCnt) : bitCnt;
  end
endmodule

// File: rtl/afrx_dpath.sv
module afrx_dpath
  import afrx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rxStb_t              stb,
  input  logic                bitVal,
  input  logic                wordRead,
  input  logic                overrunClr,
  output logic [MAX_BITS-1:0] wordData,
  output logic                wordValid,
  output logic                overrun
);
  logic [MAX_BITS-1:0] acc;
  logic [MAX_BITS-1:0] accNext;
  logic                loadOk;

  always_comb begin
    accNext = stb.firstBit ? '0 : acc;
    if (stb.takeBit) accNext[stb.bitPos] = bitVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            acc <= '0;
    else if (stb.takeBit) acc <= accNext;
  end

  assign loadOk = ~wordValid | wordRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordData  <= '0;
      wordValid <= 1'b0;
    end else if (stb.wordDone && loadOk) begin
      wordData  <= accNext;
      wordValid <= 1'b1;
    end else if (wordRead) begin
      wordValid <= 1'b0;
    end
  end

  // setting wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       overrun <= 1'b0;
    else if (stb.wordDone && !loadOk) overrun <= 1'b1;
    else if (overrunClr)             overrun <= 1'b0;
  end
endmodule

// File: rtl/audio_frame_rx.sv
module audio_frame_rx
  import afrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                frameSync,
  input  logic                serData,
  input  logic [1:0]          cfgStartMode,
  input  logic [DLY_W-1:0]    cfgDelay,
  input  logic [LEN_W-1:0]    cfgLenM1,
  input  logic [WCNT_W-1:0]   cfgWordsM1,
  input  logic                cfgMsbFirst,
  input  logic                wordRead,
  input  logic                overrunClr,
  output logic [MAX_BITS-1:0] wordData,
  output logic                wordValid,
  output logic                overrun
);
  logic   tick;
  logic   bitVal;
  logic   startEvt;
  rxStb_t ctlStb;

  afrx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .serData(serData), .startMode(cfgStartMode),
    .tick(tick), .bitVal(bitVal), .startEvt(startEvt)
  );

  afrx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .startEvt(startEvt),
    .cfgDelay(cfgDelay), .cfgLenM1(cfgLenM1), .cfgWordsM1(cfgWordsM1),
    .cfgMsbFirst(cfgMsbFirst), .stb(ctlStb)
  );

  afrx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .bitVal(bitVal),
    .wordRead(wordRead), .overrunClr(overrunClr),
    .wordData(wordData), .wordValid(wordValid), .overrun(overrun)
  );
endmodule

// File: rtl/audio_frame_rx_chk.sv
module audio_frame_rx_chk
  import afrx_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wordRead,
  input logic                overrunClr,
  input logic [MAX_BITS-1:0] wordData,
  input logic                wordValid,
  input logic                overrun,
  input rxStb_t              stb
);
  // R10: an unread word stays put
  a_r10_hold_unread: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordRead) |=> (wordValid && $stable(wordData)));

  // R10: valid only follows a completed word from the control
  a_r10_valid_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordValid) |-> $past(stb.wordDone));

  // R11: overrun is sticky until cleared
  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !overrunClr) |=> overrun);

  // R11: overrun only rises when a word completes against an unread one
  a_r11_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(stb.wordDone && wordValid && !wordRead));

  // R8: a frame ends only at a word boundary
  a_r8_frame_on_word: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameDone |-> (stb.wordDone && stb.takeBit));
endmodule

bind audio_frame_rx audio_frame_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .wordRead(wordRead), .overrunClr(overrunClr),
  .wordData(wordData), .wordValid(wordValid), .overrun(overrun), .stb(ctlStb)
);

// File: tb/audio_frame_rx_tb.sv
module audio_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClk = 1'b0;
  logic        frameSync = 1'b1;
  logic        serData = 1'b0;
  logic [1:0]  cfgStartMode = 2'd0;
  logic [3:0]  cfgDelay = 4'd1;
  logic [4:0]  cfgLenM1 = 5'd15;
  logic [0:0]  cfgWordsM1 = 1'b0;
  logic        cfgMsbFirst = 1'b1;
  logic        wordRead = 1'b0;
  logic        overrunClr = 1'b0;
  logic [31:0] wordData;
  logic        wordValid;
  logic        overrun;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit autoRead = 1;
  logic [31:0] got[$];
  logic [31:0] vals[2];
  logic fsLevel = 1'b1;

  always #5 clk = ~clk;

  audio_frame_rx u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .serData(serData), .cfgStartMode(cfgStartMode), .cfgDelay(cfgDelay),
    .cfgLenM1(cfgLenM1), .cfgWordsM1(cfgWordsM1), .cfgMsbFirst(cfgMsbFirst),
    .wordRead(wordRead), .overrunClr(overrunClr),
    .wordData(wordData), .wordValid(wordValid), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // consumer: acknowledges each valid word for one cycle
  initial begin
    forever begin
      @(negedge clk);
      if (autoRead && wordValid && !wordRead) begin
        got.push_back(wordData);
        wordRead = 1'b1;
      end else begin
        wordRead = 1'b0;
      end
    end
  end

  // one bit period: data set while low, disturbed in mid-high (R5)
  task automatic sendTick(input logic fs, input logic d);
    @(negedge clk);
    frameSync = fs;
    serData = d;
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    repeat (2) @(negedge clk);
    serData = ~d;
    repeat (2) @(negedge clk);
    bitClk = 1'b0;
  endtask

  function automatic logic bitOf(input int b, input int len, input int msb);
    int w = b / len;
    int i = b % len;
    return msb ? vals[w][len-1-i] : vals[w][i];
  endfunction

  function automatic logic [31:0] makeVal(input int seed, input int len);
    logic [63:0] m = (64'd1 << len) - 64'd1;
    logic [63:0] v = (64'hA5C3_9E17 * (seed + 1)) ^ 64'h3C96_5A0F_7E21_D4B8 ^ (64'(seed) << 7);
    return 32'(v & m);
  endfunction

  task automatic runFrame(input int mode, input int dly, input int len, input int nw,
                          input int msb, input int tA, input int tB);
    logic idleLvl;
    logic fsCur;
    int nTicks;
    idleLvl = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : fsLevel;
    repeat (2) sendTick(idleLvl, 1'b0);
    fsCur = ~idleLvl;
    nTicks = dly + len * nw;
    for (int j = 0; j < nTicks; j++) begin
      int b = j - dly;
      if (j == tA || j == tB) fsCur = ~fsCur;
      sendTick(fsCur, (b >= 0) ? bitOf(b, len, msb) : 1'b0);
    end
    fsLevel = fsCur;
    repeat (2) sendTick(fsCur, 1'b0);
    repeat (12) @(negedge clk);
  endtask

  task automatic setCfg(input int mode, input int dly, input int len, input int nw, input int msb);
    @(negedge clk);
    cfgStartMode = 2'(mode);
    cfgDelay = 4'(dly);
    cfgLenM1 = 5'(len - 1);
    cfgWordsM1 = 1'(nw - 1);
    cfgMsbFirst = 1'(msb);
  endtask

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    check(wordValid == 1'b0, "R12 wordValid in reset", 32'(wordValid), 32'd0);
    check(overrun == 1'b0, "R12 overrun in reset", 32'(overrun), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(wordData == 32'd0, "R12 wordData after reset", wordData, 32'd0);
    check(wordValid == 1'b0, "R12 wordValid after reset", 32'(wordValid), 32'd0);

    // sweep: R1 R2 R3 R4 R5 R6 R7 R8
    for (int li = 0; li < 4; li++) begin
      for (int nw = 1; nw <= 2; nw++) begin
        for (int msb = 0; msb < 2; msb++) begin
          for (int mode = 0; mode < 3; mode++) begin
            int len = 8 * (li + 1);
            int dly = (idx / 3) % 3;
            string tag = (mode == 0) ? "R1" : (mode == 1) ? "R2" : "R3";
            vals[0] = makeVal(idx * 2, len);
            vals[1] = makeVal(idx * 2 + 1, len);
            setCfg(mode, dly, len, nw, msb);
            got.delete();
            runFrame(mode, dly, len, nw, msb, -1, -1);
            check(got.size() == nw, $sformatf("R8 %s word count len%0d", tag, len), 32'(got.size()), 32'(nw));
            for (int w = 0; w < nw; w++) begin
              if (w < got.size())
                check(got[w] == vals[w],
                      $sformatf("%s R4 R5 R6 R7 word%0d len%0d msb%0d dly%0d", tag, w, len, msb, dly),
                      got[w], vals[w]);
            end
            idx++;
          end
        end
      end
    end

    // R9: edges inside a frame are ignored
    vals[0] = 32'h0000_B3A5;
    vals[1] = 32'h0000_4C19;
    setCfg(2, 1, 16, 2, 1);
    got.delete();
    runFrame(2, 1, 16, 2, 1, 10, 12);
    check(got.size() == 2, "R9 mid-frame edges ignored count", 32'(got.size()), 32'd2);
    if (got.size() >= 2) begin
      check(got[0] == vals[0], "R9 word0 after ignored edges", got[0], vals[0]);
      check(got[1] == vals[1], "R9 word1 after ignored edges", got[1], vals[1]);
    end

    // R9 R3: event on the final bit opens the next frame back to back
    vals[0] = 32'h0000_9D27;
    vals[1] = 32'h0000_62E8;
    setCfg(2, 1, 16, 1, 1);
    got.delete();
    begin
      logic fsCur = fsLevel;
      repeat (2) sendTick(fsCur, 1'b0);
      fsCur = ~fsCur;
      for (int j = 0; j <= 32; j++) begin
        logic d = 1'b0;
        if (j == 16) fsCur = ~fsCur;
        if (j >= 1 && j <= 16) d = vals[0][16 - j];
        if (j >= 17) d = vals[1][32 - j];
        sendTick(fsCur, d);
      end
      fsLevel = fsCur;
      repeat (2) sendTick(fsCur, 1'b0);
      repeat (12) @(negedge clk);
    end
    check(got.size() == 2, "R9 back-to-back word count", 32'(got.size()), 32'd2);
    if (got.size() >= 2) begin
      check(got[0] == vals[0], "R9 back-to-back left", got[0], vals[0]);
      check(got[1] == vals[1], "R9 back-to-back right", got[1], vals[1]);
    end

    // R11 R10: overrun keeps the older word
    vals[0] = 32'h0000_00C6;
    vals[1] = 32'h0000_0035;
    setCfg(0, 1, 8, 2, 1);
    got.delete();
    autoRead = 0;
    runFrame(0, 1, 8, 2, 1, -1, -1);
    check(wordValid == 1'b1, "R10 word held unread", 32'(wordValid), 32'd1);
    check(wordData == vals[0], "R11 older word kept", wordData, vals[0]);
    check(overrun == 1'b1, "R11 overrun set", 32'(overrun), 32'd1);
    repeat (5) @(negedge clk);
    check(overrun == 1'b1, "R11 overrun sticky", 32'(overrun), 32'd1);
    overrunClr = 1'b1;
    @(negedge clk);
    overrunClr = 1'b0;
    @(negedge clk);
    check(overrun == 1'b0, "R11 overrun cleared", 32'(overrun), 32'd0);
    check(wordData == vals[0], "R10 data stable through clear", wordData, vals[0]);
    autoRead = 1;
    repeat (4) @(negedge clk);
    check(got.size() == 1, "R10 single held word read", 32'(got.size()), 32'd1);
    check(wordValid == 1'b0, "R10 valid drops after read", 32'(wordValid), 32'd0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule